// File: doc/BRIEF.md
# Operand Cache with Write-Back Buffer

This block is a direct-mapped data cache controller placed between a CPU load/store port and a word-wide external memory port. It has sixteen lines of four 32-bit words. Each line carries a valid flag, a modified flag and a 24-bit tag. The `wbMode` input selects the write policy for each access. When it is high, stores stay in the cache. When it is low, every store goes straight through to memory.

When a miss replaces a modified line, the victim's line address and its four words are copied into a single holding slot. The refill of the new line goes to memory first. The CPU access then completes, and the holding slot empties to memory in the background while later hits are still served.

The CPU keeps `cpuReq` and its address and data steady until `cpuReady` is high at a rising edge. The memory side keeps `memReq` and its address steady until `memAck` is high at a rising edge, and moves one word per acknowledge.

Top module: `opcache_wb`

## Requirements
- R1: A read that hits raises `cpuReady` in the same cycle as the request and returns the cached word. It makes no memory access and changes no cache state.
- R2: A read miss fetches the whole line with four memory reads in ascending word order, at `{addr[31:4], k, 2'b00}` for k = 0 to 3, and then returns the requested word. This holds under either policy.
- R3: Under write-back (`wbMode`=1), a write hit completes in the request cycle with no memory access. It updates the cached word and marks the line modified.
- R4: Under write-through (`wbMode`=0), a write hit performs one memory write of `cpuWdata` to `cpuAddr`. It finishes on that write's acknowledge and also updates the cached word.
- R5: Under write-through, a write miss performs one memory write and allocates no line. A later read of that address misses and fetches the line.
- R6: Under write-back, a write miss first fetches the line and then merges the store into it. The line ends up modified and holds the stored word.
- R7: A miss whose victim is valid and modified, in either policy, fetches the new line first. It then writes the victim back as four ascending word writes to `{3'b000, victimAddr[28:4], k, 2'b00}`, so the top three address bits are zero.
- R8: A miss whose victim is clean or invalid performs only the four fetch reads, with no memory writes.
- R9: While the holding slot drains, hits are still served in a single cycle. Any access that needs the memory port waits until the last write-back word is acknowledged.
- R10: During and right after reset, `cpuReady` and `memReq` are low and every line is invalid.
- R11: Once `memReq` is raised, it stays high with `memAddr` and `memWe` unchanged until `memAck` is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wbMode | input | 1 | 1 = write-back policy, 0 = write-through |
| cpuReq | input | 1 | CPU access request, held until `cpuReady` |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | CPU byte address (word aligned) |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid while `cpuReady` is high on a load |
| cpuReady | output | 1 | Access completes at this rising edge |
| memReq | output | 1 | Memory word request |
| memWe | output | 1 | 1 = memory write, 0 = memory read |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, sampled with `memAck` |
| memAck | input | 1 | Memory word completes at this rising edge |

## Verification
A write-back of the holding slot and a CPU hit can share a cycle. In that cycle `memReq` is high for a drain word while `cpuReady` answers a read from the cache.

The bench sets this up by evicting a modified line with a read miss and then reading another word of the freshly filled line at once. At the cycle the hit is accepted, it requires a zero-wait response with the correct data and `memReq` still high.

The scoreboard then requires every write-back word to arrive in order, with the correct data. It also requires that a miss issued during the drain places its fetch reads only after the last write-back word.

// File: rtl/opcache_pkg.sv
package opcache_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int WORDS   = 4;
  localparam int LINES   = 16;
  localparam int ZERO_HI = 3;
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int WSEL_W  = $clog2(WORDS);
  localparam int OFF_W   = WSEL_W + BYTE_W;
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W  = ADDR_W - OFF_W;

  typedef enum logic [1:0] {SEL_FILL, SEL_WT, SEL_DRAIN} memSel_e;

  typedef struct packed {
    logic              fillWr;
    logic              fillDone;
    logic              cpuWr;
    logic              setDirty;
    logic              bufLoad;
    memSel_e           memSel;
    logic [WSEL_W-1:0] fillIdx;
    logic [WSEL_W-1:0] drainIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/opcache_dp.sv
module opcache_dp
  import opcache_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              hit,
  output logic              victimDirty,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES][WORDS];
  logic [LINES-1:0]  validArr, dirtyArr;
  logic [LINE_W-1:0] bufLine;
  logic [DATA_W-1:0] bufData [WORDS];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wordSel;

  assign idx     = cpuAddr[OFF_W +: IDX_W];
  assign tag     = cpuAddr[ADDR_W-1 -: TAG_W];
  assign wordSel = cpuAddr[BYTE_W +: WSEL_W];

  assign hit         = validArr[idx] && (tagArr[idx] == tag);
  assign victimDirty = validArr[idx] && dirtyArr[idx];
  assign cpuRdata    = dataArr[idx][wordSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validArr <= '0;
      dirtyArr <= '0;
    end else if (strobe.fillDone) begin
      validArr[idx] <= 1'b1;
      dirtyArr[idx] <= 1'b0;
    end else if (strobe.setDirty) begin
      dirtyArr[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWr) dataArr[idx][strobe.fillIdx] <= memRdata;
    if (strobe.cpuWr)  dataArr[idx][wordSel] <= cpuWdata;
    if (strobe.fillDone) tagArr[idx] <= tag;
    if (strobe.bufLoad) begin
      bufLine <= {{ZERO_HI{1'b0}}, tagArr[idx][TAG_W-ZERO_HI-1:0], idx};
      for (int w = 0; w < WORDS; w++) bufData[w] <= dataArr[idx][w];
    end
  end

  always_comb begin
    unique case (strobe.memSel)
      SEL_FILL: memAddr = {cpuAddr[ADDR_W-1:OFF_W], strobe.fillIdx, {BYTE_W{1'b0}}};
      SEL_WT:   memAddr = cpuAddr;
      default:  memAddr = {bufLine, strobe.drainIdx, {BYTE_W{1'b0}}};
    endcase
    memWdata = (strobe.memSel == SEL_WT) ? cpuWdata : bufData[strobe.drainIdx];
  end

  // R2
  fill_marks_valid_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillDone |=> validArr[$past(idx)] && !dirtyArr[$past(idx)]);

  // R3
  store_marks_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setDirty |=> dirtyArr[$past(idx)]);
endmodule

// File: rtl/opcache_ctrl.sv
module opcache_ctrl
  import opcache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wbMode,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        hit,
  input  logic        victimDirty,
  input  logic        memAck,
  output logic        cpuReady,
  output logic        memReq,
  output logic        memWe,
  output ctrlStrobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_WTWR} state_e;

  state_e            state, nextState;
  logic [WSEL_W-1:0] fillCnt, drainCnt;
  logic              bufValid;
  logic              lastFill, lastDrain, drainAck;

  assign lastFill  = (fillCnt == WSEL_W'(WORDS - 1));
  assign lastDrain = (drainCnt == WSEL_W'(WORDS - 1));
  assign drainAck  = (state == ST_IDLE) && bufValid && memAck;

  always_comb begin
    strobe          = '0;
    strobe.memSel   = SEL_DRAIN;
    strobe.fillIdx  = fillCnt;
    strobe.drainIdx = drainCnt;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (bufValid) begin
          memReq = 1'b1;
          memWe  = 1'b1;
        end
        if (cpuReq) begin
          if (hit && !cpuWe) begin
            cpuReady = 1'b1;
          end else if (hit && wbMode) begin
            cpuReady        = 1'b1;
            strobe.cpuWr    = 1'b1;
            strobe.setDirty = 1'b1;
          end else if (!bufValid) begin
            if (cpuWe && !wbMode) begin
              nextState = ST_WTWR;
            end else begin
              nextState      = ST_FILL;
              strobe.bufLoad = victimDirty;
            end
          end
        end
      end
      ST_FILL: begin
        memReq        = 1'b1;
        strobe.memSel = SEL_FILL;
        if (memAck) begin
          strobe.fillWr = 1'b1;
          if (lastFill) begin
            strobe.fillDone = 1'b1;
            nextState       = ST_IDLE;
          end
        end
      end
      default: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        strobe.memSel = SEL_WT;
        if (memAck) begin
          cpuReady     = 1'b1;
          strobe.cpuWr = hit;
          nextState    = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fillCnt  <= '0;
      drainCnt <= '0;
      bufValid <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_FILL && memAck) fillCnt <= fillCnt + 1'b1;
      if (drainAck) drainCnt <= drainCnt + 1'b1;
      if (strobe.bufLoad) bufValid <= 1'b1;
      else if (drainAck && lastDrain) bufValid <= 1'b0;
    end
  end

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe));

  // R1
  ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuReq);

  // R9
  buf_load_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bufLoad |-> !bufValid);

  // R7
  buf_fill_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufValid) |-> state == ST_FILL);
endmodule

// File: rtl/opcache_wb.sv
module opcache_wb
  import opcache_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbMode,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);
  ctrlStrobe_t strobe;
  logic        hit, victimDirty;

  opcache_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wbMode(wbMode), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .hit(hit), .victimDirty(victimDirty), .memAck(memAck),
    .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe), .strobe(strobe)
  );

  opcache_dp uDp (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .strobe(strobe), .memRdata(memRdata), .hit(hit), .victimDirty(victimDirty),
    .cpuRdata(cpuRdata), .memAddr(memAddr), .memWdata(memWdata)
  );
endmodule

// File: tb/sim_opcache_wb.sv
module sim_opcache_wb;
  logic        clk = 1'b0;
  logic        rstN, wbMode, cpuReq, cpuWe, cpuReady;
  logic [31:0] cpuAddr, cpuWdata, cpuRdata;
  logic        memReq, memWe, memAck;
  logic [31:0] memAddr, memWdata, memRdata;

  always #4 clk = ~clk;

  opcache_wb u0 (
    .clk(clk), .rstN(rstN), .wbMode(wbMode), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    string       req;
  } memTx_t;

  memTx_t      expQ[$];
  logic [31:0] mem [256];
  int          nRun = 0;
  int          nFail = 0;
  int          waitCnt = 0;
  logic [31:0] holdAddr;

  function automatic void chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endfunction

  function automatic void pushTx(bit we, logic [31:0] a, logic [31:0] d, string req);
    memTx_t t;
    t.we = we; t.addr = a; t.data = d; t.req = req;
    expQ.push_back(t);
  endfunction

  function automatic void pushFill(logic [31:0] lineAddr, string req);
    for (int k = 0; k < 4; k++) pushTx(1'b0, lineAddr + 32'(4 * k), 32'h0, req);
  endfunction

  // memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (!rstN) begin
      memAck  <= 1'b0;
      waitCnt <= 0;
    end else if (memAck) begin
      memAck  <= 1'b0;
      waitCnt <= 0;
    end else if (memReq) begin
      if (waitCnt > 0) chk(memAddr === holdAddr, "R11", "memAddr held", memAddr, holdAddr);
      holdAddr <= memAddr;
      if (waitCnt < (memAddr[2] ? 1 : 0)) begin
        waitCnt <= waitCnt + 1;
      end else begin
        memAck <= 1'b1;
        if (expQ.size() == 0) begin
          chk(1'b0, "R8", "unexpected memory access", memAddr, 32'hx);
        end else begin
          memTx_t t;
          t = expQ.pop_front();
          chk(memWe === t.we && memAddr === t.addr, t.req, "memory access addr",
              memAddr, t.addr);
          if (t.we) chk(memWdata === t.data, t.req, "memory write data", memWdata, t.data);
        end
        if (memWe) mem[memAddr[9:2]] <= memWdata;
        else memRdata <= mem[memAddr[9:2]];
      end
    end
  end

  task automatic cpuOp(input bit we, input logic [31:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output int waits, output logic busy);
    @(negedge clk);
    #1;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    waits = 0;
    #1;
    while (!cpuReady) begin
      @(negedge clk);
      #2;
      waits++;
    end
    rd   = cpuRdata;
    busy = memReq;
    @(posedge clk);
    #1;
    cpuReq = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          w;
    logic        busy;
    logic [31:0] d1, d2, d3, d4, d5;
    d1 = 32'hD1D1_0001; d2 = 32'hD2D2_0002; d3 = 32'hD3D3_0003;
    d4 = 32'hD4D4_0004; d5 = 32'hD5D5_0005;
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 | 32'(i);
    rstN = 1'b0; wbMode = 1'b1; cpuReq = 1'b0; cpuWe = 1'b0;
    cpuAddr = '0; cpuWdata = '0; memRdata = '0; memAck = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(cpuReady === 1'b0, "R10", "cpuReady in reset", 32'(cpuReady), 0);
    chk(memReq === 1'b0, "R10", "memReq in reset", 32'(memReq), 0);
    rstN = 1'b1;

    // R2 read miss after reset (R10: line invalid)
    pushFill(32'h100, "R2");
    cpuOp(1'b0, 32'h108, 0, rd, w, busy);
    chk(rd === mem[66], "R2", "fill read data", rd, mem[66]);
    chk(w > 0, "R10", "first access misses", 32'(w), 1);

    // R1 read hit
    cpuOp(1'b0, 32'h10C, 0, rd, w, busy);
    chk(rd === mem[67], "R1", "hit data", rd, mem[67]);
    chk(w == 0, "R1", "hit zero wait", 32'(w), 0);

    // R3 write-back write hit
    cpuOp(1'b1, 32'h104, d1, rd, w, busy);
    chk(w == 0, "R3", "wb store hit zero wait", 32'(w), 0);
    cpuOp(1'b0, 32'h104, 0, rd, w, busy);
    chk(rd === d1, "R3", "stored word read back", rd, d1);

    // R6 write-back write miss evicting dirty line; R7 order; R9 miss waits for drain
    pushFill(32'h200, "R7");
    pushTx(1'b1, 32'h100, mem[64], "R7");
    pushTx(1'b1, 32'h104, d1, "R7");
    pushTx(1'b1, 32'h108, mem[66], "R7");
    pushTx(1'b1, 32'h10C, mem[67], "R7");
    cpuOp(1'b1, 32'h204, d2, rd, w, busy);
    chk(w > 0, "R6", "store miss stalls for fill", 32'(w), 1);
    pushFill(32'h120, "R9");
    cpuOp(1'b0, 32'h128, 0, rd, w, busy);
    chk(rd === mem[74], "R9", "read after drain", rd, mem[74]);
    cpuOp(1'b0, 32'h204, 0, rd, w, busy);
    chk(rd === d2, "R6", "merged store word", rd, d2);
    chk(w == 0, "R6", "merged line is a hit", 32'(w), 0);

    // R7 high address bits cleared on write-back; R9 hit during drain
    pushFill(32'hE000_0310, "R6");
    cpuOp(1'b1, 32'hE000_0314, d5, rd, w, busy);
    pushFill(32'h410, "R7");
    pushTx(1'b1, 32'h0000_0310, mem[196], "R7");
    pushTx(1'b1, 32'h0000_0314, d5, "R7");
    pushTx(1'b1, 32'h0000_0318, mem[198], "R7");
    pushTx(1'b1, 32'h0000_031C, mem[199], "R7");
    cpuOp(1'b0, 32'h418, 0, rd, w, busy);
    chk(rd === mem[6], "R2", "fill read data", rd, mem[6]);
    cpuOp(1'b0, 32'h410, 0, rd, w, busy);
    chk(w == 0, "R9", "hit during drain zero wait", 32'(w), 0);
    chk(busy === 1'b1, "R9", "drain active during hit", 32'(busy), 1);
    chk(rd === mem[4], "R9", "hit data during drain", rd, mem[4]);
    repeat (20) @(posedge clk);

    // R8 clean eviction
    pushFill(32'h520, "R8");
    cpuOp(1'b0, 32'h520, 0, rd, w, busy);
    chk(rd === mem[72], "R8", "clean eviction fill data", rd, mem[72]);
    repeat (20) @(posedge clk);
    chk(expQ.size() == 0, "R8", "no write-back pending", 32'(expQ.size()), 0);

    // R4 write-through write hit
    wbMode = 1'b0;
    pushTx(1'b1, 32'h524, d3, "R4");
    cpuOp(1'b1, 32'h524, d3, rd, w, busy);
    chk(w > 0, "R4", "wt store waits for ack", 32'(w), 1);
    cpuOp(1'b0, 32'h524, 0, rd, w, busy);
    chk(rd === d3, "R4", "cached word updated", rd, d3);
    chk(w == 0, "R4", "read back is hit", 32'(w), 0);

    // R5 write-through write miss does not allocate
    pushTx(1'b1, 32'h634, d4, "R5");
    cpuOp(1'b1, 32'h634, d4, rd, w, busy);
    pushFill(32'h630, "R5");
    cpuOp(1'b0, 32'h634, 0, rd, w, busy);
    chk(w > 0, "R5", "no allocation, read misses", 32'(w), 1);
    chk(rd === d4, "R5", "read returns stored word", rd, d4);

    repeat (10) @(posedge clk);
    chk(expQ.size() == 0, "R7", "all expected accesses seen", 32'(expQ.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule